// File: doc/BRIEF.md
# Floating-Point Register Boxing and Unboxing Unit

This unit sits between a 128-bit floating-point register file and execution units that work in single (32-bit), double (64-bit) or quad (128-bit) precision. On the write side it widens a result to a full register entry. The bits above the result's own width are filled with ones, so a narrow value always looks like a NaN to any wider format.

On the read side it takes a stored entry and a requested format. It checks that the bits above that format are all ones. If they are, the operand is passed on. If they are not, the operand is replaced with the canonical quiet NaN of the requested format. The unboxed operand is zero-extended to 128 bits and registered, so it appears one cycle after the read request. Two further outputs give the low 64 and low 32 bits of the entry with no boxing check; these serve register moves and stores. Two combinational flags report whether the entry is validly boxed as a single or as a double.

Format codes are shared by both sides: 2'b00 single, 2'b01 double, 2'b11 quad, and 2'b10 is reserved and behaves as quad.

Top module: `fp_box_unit`

## Requirements
- R1: With wr_fmt = 2'b00, wr_entry equals {96 one bits, wr_val[31:0]} in the same cycle.
- R2: With wr_fmt = 2'b01, wr_entry equals {64 one bits, wr_val[63:0]} in the same cycle.
- R3: With wr_fmt = 2'b11 or 2'b10, wr_entry equals wr_val unchanged.
- R4: ok_double is 1 exactly when rd_entry[127:64] is all ones. ok_single is 1 exactly when ok_double is 1 and rd_entry[63:32] is all ones. Both flags are combinational.
- R5: A read with rd_fmt = 2'b01 yields {64'b0, rd_entry[63:0]} if ok_double, else {64'b0, 64'h7FF8000000000000}.
- R6: A read with rd_fmt = 2'b00 yields {96'b0, rd_entry[31:0]} if ok_single, else {96'b0, 32'h7FC00000}. An entry whose bits 63:32 are ones but whose upper half is not all ones also yields the NaN.
- R7: A read with rd_fmt = 2'b11 or 2'b10 yields rd_entry unchanged.
- R8: raw_dword equals rd_entry[63:0] and raw_word equals rd_entry[31:0] combinationally, whatever the boxing.
- R9: rd_data and rd_valid update on the clock edge that samples rd_en high: rd_valid is 1 in the following cycle. When rd_en is low, rd_valid returns to 0 and rd_data holds its value.
- R10: While rst_n is low, rd_valid and rd_data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_fmt | input | 2 | Format of the result being written |
| wr_val | input | 128 | Result from an execution unit, low bits significant |
| wr_entry | output | 128 | Boxed entry for the register file |
| rd_entry | input | 128 | Entry read from the register file |
| rd_fmt | input | 2 | Format the consumer requests |
| rd_en | input | 1 | Read request, captures the unboxed operand |
| rd_data | output | 128 | Unboxed operand, zero-extended, registered |
| rd_valid | output | 1 | rd_data was captured on the previous edge |
| raw_dword | output | 64 | Low half of rd_entry with no boxing check |
| raw_word | output | 32 | Low word of rd_entry with no boxing check |
| ok_single | output | 1 | rd_entry is a validly boxed single |
| ok_double | output | 1 | rd_entry is a validly boxed double |

## Verification
The write boxing, the raw extracts and the two validity flags are combinational. They are due in the same cycle as their inputs. The bench drives inputs just after a falling edge and samples these outputs a step later, before the next rising edge. The unboxed operand and rd_valid are due one rising edge after rd_en is sampled high. The bench therefore holds each read request across exactly one rising edge and checks rd_data at the next falling edge. In that same window it also shows that changing rd_entry with rd_en low leaves rd_data untouched.

// File: rtl/fp_box_unit.sv
module fp_box_unit #(
  parameter int          REG_W   = 128,
  parameter int          DP_W    = 64,
  parameter int          SP_W    = 32,
  parameter logic [31:0] SP_QNAN = 32'h7FC0_0000,
  parameter logic [63:0] DP_QNAN = 64'h7FF8_0000_0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        wr_fmt,
  input  logic [REG_W-1:0]  wr_val,
  output logic [REG_W-1:0]  wr_entry,
  input  logic [REG_W-1:0]  rd_entry,
  input  logic [1:0]        rd_fmt,
  input  logic              rd_en,
  output logic [REG_W-1:0]  rd_data,
  output logic              rd_valid,
  output logic [DP_W-1:0]   raw_dword,
  output logic [SP_W-1:0]   raw_word,
  output logic              ok_single,
  output logic              ok_double
);

  localparam int          DP_PAD = REG_W - DP_W;
  localparam int          SP_PAD = REG_W - SP_W;
  localparam logic [1:0]  FMT_S  = 2'b00;
  localparam logic [1:0]  FMT_D  = 2'b01;

  logic [REG_W-1:0] unboxed;

  always_comb begin
    case (wr_fmt)
      FMT_S:   wr_entry = {{SP_PAD{1'b1}}, wr_val[SP_W-1:0]};
      FMT_D:   wr_entry = {{DP_PAD{1'b1}}, wr_val[DP_W-1:0]};
      default: wr_entry = wr_val;
    endcase
  end

  assign ok_double = &rd_entry[REG_W-1:DP_W];
  assign ok_single = ok_double & (&rd_entry[DP_W-1:SP_W]);
  assign raw_dword = rd_entry[DP_W-1:0];
  assign raw_word  = rd_entry[SP_W-1:0];

  always_comb begin
    case (rd_fmt)
      FMT_S:   unboxed = {{SP_PAD{1'b0}}, ok_single ? rd_entry[SP_W-1:0] : SP_QNAN};
      FMT_D:   unboxed = {{DP_PAD{1'b0}}, ok_double ? rd_entry[DP_W-1:0] : DP_QNAN};
      default: unboxed = rd_entry;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= unboxed;
    end
  end

endmodule

// File: rtl/fp_box_unit_chk.sv
module fp_box_unit_chk (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   wr_fmt,
  input logic [127:0] wr_entry,
  input logic [127:0] rd_entry,
  input logic [1:0]   rd_fmt,
  input logic         rd_en,
  input logic [127:0] rd_data,
  input logic         rd_valid,
  input logic         ok_single,
  input logic         ok_double
);

  a_r1_sp_box: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fmt == 2'b00) |-> (&wr_entry[127:32]));

  a_r2_dp_box: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fmt == 2'b01) |-> (&wr_entry[127:64]));

  a_r4_sp_implies_dp: assert property (@(posedge clk) disable iff (!rst_n)
    ok_single |-> ok_double);

  a_r5_dp_nan: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_fmt == 2'b01 && !(&rd_entry[127:64]))
      |=> (rd_data == {64'b0, 64'h7FF8_0000_0000_0000}));

  a_r6_sp_nan: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_fmt == 2'b00 && !(&rd_entry[127:32]))
      |=> (rd_data == {96'b0, 32'h7FC0_0000}));

  a_r9_valid_set: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  a_r9_valid_clr: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

endmodule

bind fp_box_unit fp_box_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_fmt(wr_fmt), .wr_entry(wr_entry),
  .rd_entry(rd_entry), .rd_fmt(rd_fmt), .rd_en(rd_en), .rd_data(rd_data),
  .rd_valid(rd_valid), .ok_single(ok_single), .ok_double(ok_double)
);

// File: tb/fp_box_unit_tb.sv
module fp_box_unit_tb;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   wr_fmt = 2'b00;
  logic [127:0] wr_val = '0;
  logic [127:0] wr_entry;
  logic [127:0] rd_entry = '0;
  logic [1:0]   rd_fmt = 2'b00;
  logic         rd_en = 1'b0;
  logic [127:0] rd_data;
  logic         rd_valid;
  logic [63:0]  raw_dword;
  logic [31:0]  raw_word;
  logic         ok_single;
  logic         ok_double;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  fp_box_unit u_dut (
    .clk(clk), .rst_n(rst_n), .wr_fmt(wr_fmt), .wr_val(wr_val), .wr_entry(wr_entry),
    .rd_entry(rd_entry), .rd_fmt(rd_fmt), .rd_en(rd_en), .rd_data(rd_data),
    .rd_valid(rd_valid), .raw_dword(raw_dword), .raw_word(raw_word),
    .ok_single(ok_single), .ok_double(ok_double)
  );

  localparam logic [127:0] ONES96 = {{96{1'b1}}, 32'h0};
  localparam logic [127:0] ONES64 = {{64{1'b1}}, 64'h0};
  localparam logic [127:0] SNAN   = {96'b0, 32'h7FC0_0000};
  localparam logic [127:0] DNAN   = {64'b0, 64'h7FF8_0000_0000_0000};

  localparam int NV = 8;
  localparam logic [127:0] V_ENT [NV] = '{
    ONES96 | 128'h3F80_0000,
    ONES64 | 128'h3F80_0000,
    {64'h0, 64'hFFFF_FFFF_4049_0FDB},
    ONES64 | 128'h4009_21FB_5444_2D18,
    {64'hFFFF_FFFF_FFFF_FFFE, 64'h4009_21FB_5444_2D18},
    ONES96 | 128'h3F80_0000,
    128'h4000_1234_5678_9ABC_DEF0_0000_1111_2222,
    128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210
  };
  localparam logic [1:0] V_FMT [NV] = '{2'b00, 2'b00, 2'b00, 2'b01, 2'b01, 2'b01, 2'b11, 2'b10};
  localparam logic [127:0] V_EXP [NV] = '{
    {96'b0, 32'h3F80_0000},
    SNAN,
    SNAN,
    {64'b0, 64'h4009_21FB_5444_2D18},
    DNAN,
    {64'b0, 64'hFFFF_FFFF_3F80_0000},
    128'h4000_1234_5678_9ABC_DEF0_0000_1111_2222,
    128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210
  };
  localparam logic [1:0] V_OK [NV] = '{2'b11, 2'b01, 2'b00, 2'b01, 2'b00, 2'b11, 2'b00, 2'b00};

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [127:0] ent, input logic [1:0] fmt,
                         input logic [127:0] exp, input logic [1:0] okx, input string req);
    @(negedge clk);
    rd_entry = ent; rd_fmt = fmt; rd_en = 1'b1;
    #1;
    chk("R4", {126'b0, ok_single, ok_double}, {126'b0, okx});
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, rd_data, exp);
    chk("R9", {127'b0, rd_valid}, 128'd1);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rd_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10", {127'b0, rd_valid}, 128'd0);
    chk("R10", rd_data, 128'd0);
    rd_en = 1'b0;
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string tag;
      case (V_FMT[i])
        2'b00:   tag = "R6";
        2'b01:   tag = "R5";
        default: tag = "R7";
      endcase
      do_read(V_ENT[i], V_FMT[i], V_EXP[i], V_OK[i], tag);
    end

    @(negedge clk);
    wr_val = 128'hAAAA_BBBB_CCCC_DDDD_EEEE_FFFF_1234_5678;
    wr_fmt = 2'b00; #1;
    chk("R1", wr_entry, ONES96 | 128'h1234_5678);
    wr_fmt = 2'b01; #1;
    chk("R2", wr_entry, ONES64 | 128'hEEEE_FFFF_1234_5678);
    wr_fmt = 2'b11; #1;
    chk("R3", wr_entry, wr_val);
    wr_fmt = 2'b10; #1;
    chk("R3", wr_entry, wr_val);

    rd_entry = 128'h0000_0000_0000_0001_DEAD_BEEF_CAFE_F00D; #1;
    chk("R8", {64'b0, raw_dword}, {64'b0, 64'hDEAD_BEEF_CAFE_F00D});
    chk("R8", {96'b0, raw_word}, {96'b0, 32'hCAFE_F00D});

    do_read(ONES64 | 128'h5555, 2'b01, {64'b0, 64'h5555}, 2'b01, "R5");
    rd_entry = 128'h0; rd_fmt = 2'b00;
    @(negedge clk);
    chk("R9", rd_data, {64'b0, 64'h5555});
    chk("R9", {127'b0, rd_valid}, 128'd0);

    @(negedge clk);
    rst_n = 1'b0; #1;
    chk("R10", rd_data, 128'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule